// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower clock from its input clock at a rational ratio n/m, with n no larger than m. The rate is not set by a terminal count. A signed phase accumulator adds a negative step on every input cycle in which it is non-negative. On every input cycle in which it is negative, it adds a positive step and emits a one-cycle enable pulse. The negative step encodes -n and the positive step encodes m-n. Both may be scaled by a common factor to fit the 8-bit fields, so that the pulses average out to exactly n per m input cycles.

A single control word carries a run bit, a synchronous divider-reset bit, a stretch bit and the two step fields. Software reprograms the divider in a fixed order: it clears run, writes the new steps with reset set, clears reset and then sets run. With stretch clear, the output clock equals the enable pulse and is one input cycle wide. With stretch set, each output high phase lasts half the interval since the previous pulse, which brings the duty cycle close to 50%.

Top module: `frac_clk_div`

## Requirements
- R1: The control word bits are decoded as follows: bit 0 is run, bit 1 is divider reset, bit 2 is stretch, bits [10:3] hold the positive step (m-n, unsigned) and bits [18:11] hold the negative step (-n, two's complement).
- R2: With run set and reset clear, each rising input edge does one of two things. If the accumulator is non-negative, it adds the negative step. If the accumulator is negative, it adds the positive step and drives clk_en high for the following cycle. Starting from a cleared accumulator, exactly n*k pulses appear in m*k cycles.
- R3: With stretch clear, clk_out equals clk_en, and each pulse is one input cycle wide.
- R4: While the reset bit is set, the accumulator is cleared and both outputs are low after the next edge. The first pulse after release appears after the second running edge.
- R5: While run is clear (reset clear), both outputs are low after the next edge, and the accumulator keeps its value. Resuming continues the same phase, so pauses do not change the pulse count per running cycle.
- R6: With stretch set, clk_out rises together with each clk_en pulse and stays high for floor(P/2) input cycles, with a minimum of 1. P is the number of cycles since the previous pulse. clk_en stays one cycle wide.
- R7: The asynchronous active-low rst_n clears the accumulator and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 19 | Control word (run, reset, stretch, positive step, negative step) |
| clk_out | output | 1 | Divided clock, pulse-wide or stretched |
| clk_en | output | 1 | One-cycle enable at each output period |

## Verification
The embedded assertions watch several behaviours on every cycle. They check that the outputs fall low whenever the divider is stopped or reset, and that the accumulator holds while stopped and clears under reset. They also check that every enable pulse follows a negative accumulator, and that every stretched rising edge coincides with an enable. Other behaviours can only be shown by the bench's directed scenarios: the exact pulse totals over whole ratio periods for several n/m pairs, phase continuity across a pause, the first-pulse latency after release, and the stretched high length and duty.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int STEP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*STEP_W+2:0]   ctrl,
  output logic                  clk_out,
  output logic                  clk_en
);
  localparam int ACC_W = STEP_W + 2;
  localparam int GAP_W = STEP_W + 2;

  logic run, fres, fstr;
  logic [STEP_W-1:0] step_pos, step_neg;
  assign run      = ctrl[0];
  assign fres     = ctrl[1];
  assign fstr     = ctrl[2];
  assign step_pos = ctrl[3 +: STEP_W];
  assign step_neg = ctrl[3+STEP_W +: STEP_W];

  logic signed [ACC_W-1:0] acc, add_pos, add_neg;
  assign add_pos = $signed({2'b00, step_pos});
  assign add_neg = $signed({{2{step_neg[STEP_W-1]}}, step_neg});

  logic neg;
  assign neg = acc[ACC_W-1];

  logic [GAP_W-1:0] gap, hcnt, half, hi_len;
  logic pulse, st_hi;
  assign half   = gap >> 1;
  assign hi_len = (half == '0) ? GAP_W'(1) : half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      pulse <= 1'b0;
      st_hi <= 1'b0;
      hcnt  <= '0;
      gap   <= '0;
    end else if (fres) begin
      acc   <= '0;
      pulse <= 1'b0;
      st_hi <= 1'b0;
      hcnt  <= '0;
      gap   <= '0;
    end else if (!run) begin
      pulse <= 1'b0;
      st_hi <= 1'b0;
      hcnt  <= '0;
    end else begin
      acc   <= acc + (neg ? add_pos : add_neg);
      pulse <= neg;
      if (neg) begin
        gap   <= GAP_W'(1);
        st_hi <= 1'b1;
        hcnt  <= hi_len - GAP_W'(1);
      end else begin
        if (gap != '1) gap <= gap + GAP_W'(1);
        if (hcnt != '0) hcnt <= hcnt - GAP_W'(1);
        else st_hi <= 1'b0;
      end
    end
  end

  assign clk_en  = pulse;
  assign clk_out = fstr ? st_hi : pulse;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || fres) |=> (!clk_en && !clk_out)); // R5

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !fres) |=> $stable(acc)); // R5

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fres |=> (acc == '0)); // R4

  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(neg) && $past(run) && !$past(fres))); // R2

  AST_STRETCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (fstr && $past(fstr) && $rose(clk_out)) |-> clk_en); // R6
endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [18:0] ctrl = '0;
  logic clk_out, clk_en;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_clk_div u0 (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .clk_out(clk_out), .clk_en(clk_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] word(input logic [7:0] sn, input logic [7:0] sp,
                                       input bit str, input bit rs, input bit rn);
    return {sn, sp, str, rs, rn};
  endfunction

  task automatic restart(input logic [7:0] sn, input logic [7:0] sp, input bit str);
    @(negedge clk); ctrl = word(sn, sp, str, 1'b0, 1'b0);
    @(negedge clk); ctrl = word(sn, sp, str, 1'b1, 1'b0);
    @(negedge clk); ctrl = word(sn, sp, str, 1'b0, 1'b0);
    @(negedge clk); ctrl = word(sn, sp, str, 1'b0, 1'b1);
  endtask

  task automatic measure(input int total, input int skip,
                         output int en_cnt, output int hi_cnt, output int rises, output int mism);
    bit prev = 0;
    en_cnt = 0; hi_cnt = 0; rises = 0; mism = 0;
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (i > skip) begin
        en_cnt += int'(clk_en);
        hi_cnt += int'(clk_out);
        if (clk_out && !prev) rises++;
        if (clk_out != clk_en) mism++;
      end
      prev = clk_out;
    end
  endtask

  task automatic t_reset_state();
    check(clk_out == 1'b0, "R7 clk_out in reset", clk_out, 0);
    check(clk_en == 1'b0, "R7 clk_en in reset", clk_en, 0);
  endtask

  task automatic t_ratio(input logic [7:0] sn, input logic [7:0] sp, input int m, input int n, input int k);
    int e, h, r, mm;
    restart(sn, sp, 1'b0);
    measure(m*k, 0, e, h, r, mm);
    check(e == n*k, $sformatf("R2 R1 pulses %0d/%0d", n, m), e, n*k);
    check(mm == 0, $sformatf("R3 clk_out==clk_en %0d/%0d", n, m), mm, 0);
  endtask

  task automatic t_first_pulse();
    int first = 0;
    restart(8'hB0, 8'h70, 1'b0);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (clk_en && first == 0) first = i;
    end
    check(first == 2, "R4 first pulse edge", first, 2);
    ctrl = word(8'hB0, 8'h70, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!clk_en && !clk_out, "R4 outputs low while reset", int'(clk_en | clk_out), 0);
    end
    ctrl = word(8'hB0, 8'h70, 1'b0, 1'b0, 1'b1);
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (clk_en && first == 0) first = i;
    end
    check(first == 2, "R4 first pulse after mid-run reset", first, 2);
  endtask

  task automatic t_pause();
    int e1, e2, h, r, mm, idle;
    restart(8'hB0, 8'h70, 1'b1);
    measure(7, 0, e1, h, r, mm);
    ctrl = word(8'hB0, 8'h70, 1'b1, 1'b0, 1'b0);
    idle = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      idle += int'(clk_en) + int'(clk_out);
    end
    check(idle == 0, "R5 outputs low while stopped", idle, 0);
    ctrl = word(8'hB0, 8'h70, 1'b1, 1'b0, 1'b1);
    measure(17, 0, e2, h, r, mm);
    check(e1 + e2 == 10, "R5 phase kept across pause", e1 + e2, 10);
  endtask

  task automatic t_stretch();
    int e, h, r, mm;
    restart(8'hF0, 8'h90, 1'b1);
    measure(100, 20, e, h, r, mm);
    check(r == 8, "R6 rises 1/10", r, 8);
    check(h == 40, "R6 high cycles 1/10", h, 40);
    check(e == 8, "R6 clk_en single 1/10", e, 8);
    restart(8'hFF, 8'h01, 1'b1);
    measure(100, 20, e, h, r, mm);
    check(h == 40, "R6 high cycles 1/2", h, 40);
    check(r == 40, "R6 rises 1/2", r, 40);
    restart(8'hF0, 8'h90, 1'b0);
    measure(100, 20, e, h, r, mm);
    check(h == 8, "R3 unstretched high 1/10", h, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_ratio(8'hB0, 8'h70, 12, 5, 4);
    t_ratio(8'hF0, 8'h90, 10, 1, 5);
    t_ratio(8'hFF, 8'h01, 2, 1, 20);
    t_ratio(8'hFD, 8'h05, 8, 3, 6);
    t_ratio(8'hF9, 8'h02, 9, 7, 5);
    t_first_pulse();
    t_pause();
    t_stretch();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule